// File: doc/BRIEF.md
# Interrupt Request Capture and Vector Unit

This block captures interrupt requests from two sources and hands a vector to a processor during a two-step acknowledge handshake. The first source is an external pin. In edge mode, a request flip-flop captures a rising edge and holds it. In level mode, the request follows the pin directly. The second source is a serial receive event. Its flag survives register clears and is dropped only by a read of the receive buffer.

A 3-bit mask level decides which requests reach the processor. Each source carries a fixed priority, and a source is presented only when its priority is strictly above the mask. The processor first pulses an acknowledge. It then pulses a vector read, and in that cycle the unit latches the vector of the winning source from the request state as it stands. If the request disappeared in the meantime, the unit returns a default vector. A vector fetch that picks an edge-mode pin request consumes that request.

Top module: `irq_vec_unit`

## Requirements
- R1: An asynchronous active-low reset clears both flags, selects edge mode, zeroes the latched vector and sets the mask to 7, so that no request is presented until the mask is lowered.
- R2: In edge mode a 0-to-1 change of the pin (sampled at consecutive clock edges) sets the pin flag, and the flag remains set after the pin returns low.
- R3: In level mode the pin request equals the pin input in the same cycle without a clock edge, so a high-to-low change of the pin withdraws it.
- R4: A mode write selecting level mode (mode bit 1) while in edge mode clears the pin flag, so returning to edge mode right afterwards shows no request.
- R5: While in level mode a high pin sets the pin flag, and a mode write back to edge mode (mode bit 0) keeps it set. Only a clear write with code 0x0A drops the pin flag; any other code leaves it unchanged.
- R6: The receive flag is set by a receive event and cleared only by reset or a receive-buffer read strobe; clear writes of any code, including 0x0A, leave it set.
- R7: A source is presented on irq_o only when its priority (pin 4, receive 3 by default) is strictly greater than the mask value.
- R8: When both sources are presented the higher priority wins, and the pin wins a tie; the pin vector is 0x0028 and the receive vector is 0x0040. vec_addr_o is 0xFFFF in its upper 16 bits followed by vec_o[7:0].
- R9: The vector is latched at the clock edge of a vector-read strobe that follows an acknowledge, and is computed from the requests in that cycle. If none is presented it is 0x0008 (address 0xFFFF08). A vector read with no pending acknowledge leaves vec_o unchanged.
- R10: A vector fetch that picks an edge-mode pin request clears the pin flag. A fetch in level mode, or a fetch of the receive request, clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 1 | External interrupt pin |
| rx_evt_i | input | 1 | Serial receive event, sets the receive flag |
| rx_rd_i | input | 1 | Receive-buffer read strobe |
| mode_wr_i | input | 1 | Mode register write strobe |
| mode_level_i | input | 1 | Mode value: 1 level, 0 edge |
| clr_wr_i | input | 1 | Clear register write strobe |
| clr_code_i | input | 8 | Source code written to the clear register |
| mask_wr_i | input | 1 | Mask register write strobe |
| mask_i | input | 3 | Mask level value |
| ack_i | input | 1 | Interrupt acknowledge from the processor |
| vec_rd_i | input | 1 | Vector read strobe |
| irq_o | output | 1 | Request presented to the processor |
| vec_o | output | 16 | Latched vector |
| vec_addr_o | output | 24 | Vector table address |

## Verification
The bench sweeps every mask value against every combination of pending pin and receive requests. It runs that sweep on the default unit and on a second instance with equal priorities. This separates the strict mask comparison from the priority order and the tie rule, and each iteration also checks what the fetch left behind. Directed sequences drive the pin through edge-to-level and level-to-edge changes. They show the one-sided flag clearing and separate the flag path from the direct pin path. Further sequences clear or raise requests between acknowledge and vector read, issue vector reads without an acknowledge, and write the clear register with the pin code and other codes.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  typedef enum logic {
    PIN_EDGE  = 1'b0,
    PIN_LEVEL = 1'b1
  } pin_mode_e;

  localparam int CODE_W = 8;
  localparam int MASK_W = 3;
endpackage

// File: rtl/irq_pin_src.sv
module irq_pin_src
  import irq_vec_pkg::*;
#(
  parameter logic [CODE_W-1:0] CLR_CODE = 8'h0A
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pin_i,
  input  logic              mode_wr_i,
  input  logic              mode_level_i,
  input  logic              clr_wr_i,
  input  logic [CODE_W-1:0] clr_code_i,
  input  logic              take_i,
  output logic              req_o,
  output logic              level_o
);
  pin_mode_e mode_q;
  logic      pin_q, flag_q;
  logic      rise, clr_hit;

  assign rise    = pin_i & ~pin_q;
  assign clr_hit = clr_wr_i && (clr_code_i == CLR_CODE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= PIN_EDGE;
      pin_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      pin_q <= pin_i;
      if (mode_wr_i) mode_q <= mode_level_i ? PIN_LEVEL : PIN_EDGE;
      if (mode_q == PIN_LEVEL) begin
        // pin feeds the set input directly; flag is sticky until cleared
        if (clr_hit) flag_q <= pin_i;
        else         flag_q <= flag_q | pin_i;
      end else begin
        if (mode_wr_i && mode_level_i) flag_q <= 1'b0;
        else if (rise)                 flag_q <= 1'b1;
        else if (clr_hit || take_i)    flag_q <= 1'b0;
      end
    end
  end

  assign req_o   = (mode_q == PIN_LEVEL) ? pin_i : flag_q;
  assign level_o = (mode_q == PIN_LEVEL);

  p_edge_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == PIN_EDGE && !mode_wr_i && rise) |=> req_o);

  p_to_level_clr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == PIN_EDGE && mode_wr_i && mode_level_i) |=> !flag_q);

  p_level_keep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == PIN_LEVEL && mode_wr_i && !mode_level_i && flag_q && !clr_wr_i) |=> req_o);

  p_fetch_clr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && mode_q == PIN_EDGE && !rise) |=> !flag_q);
endmodule

// File: rtl/irq_rx_src.sv
module irq_rx_src (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic rd_i,
  output logic req_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (rd_i)  flag_q <= 1'b0;
  end

  assign req_o = flag_q;

  p_rx_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !rd_i) |=> req_o);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_vec_pkg::*;
#(
  parameter int                EXT_PRIO = 4,
  parameter int                RX_PRIO  = 3,
  parameter int                VEC_W    = 16,
  parameter logic [VEC_W-1:0]  EXT_VEC  = 16'h0028,
  parameter logic [VEC_W-1:0]  RX_VEC   = 16'h0040,
  parameter logic [VEC_W-1:0]  DEF_VEC  = 16'h0008
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_req_i,
  input  logic              rx_req_i,
  input  logic              mask_wr_i,
  input  logic [MASK_W-1:0] mask_i,
  input  logic              ack_i,
  input  logic              vec_rd_i,
  output logic              irq_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic              take_ext_o
);
  localparam logic [MASK_W-1:0] EXT_P    = MASK_W'(EXT_PRIO);
  localparam logic [MASK_W-1:0] RX_P     = MASK_W'(RX_PRIO);
  localparam logic [MASK_W-1:0] MASK_MAX = '1;
  localparam bit                EXT_TIE  = (EXT_PRIO >= RX_PRIO);

  logic [MASK_W-1:0] mask_q;
  logic              pend_q;
  logic [VEC_W-1:0]  vec_q;
  logic              ext_ok, rx_ok, pick_ext, take;
  logic [VEC_W-1:0]  vec_d;

  assign ext_ok   = ext_req_i && (EXT_P > mask_q);
  assign rx_ok    = rx_req_i  && (RX_P  > mask_q);
  assign pick_ext = ext_ok && (!rx_ok || EXT_TIE);
  assign take     = vec_rd_i && pend_q;

  always_comb begin
    if (pick_ext)   vec_d = EXT_VEC;
    else if (rx_ok) vec_d = RX_VEC;
    else            vec_d = DEF_VEC;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= MASK_MAX;
      pend_q <= 1'b0;
      vec_q  <= '0;
    end else begin
      if (mask_wr_i) mask_q <= mask_i;
      pend_q <= ack_i | (pend_q & ~vec_rd_i);
      if (take) vec_q <= vec_d;
    end
  end

  assign irq_o      = ext_ok | rx_ok;
  assign vec_o      = vec_q;
  assign take_ext_o = take & pick_ext;

  p_mask_max_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == MASK_MAX) |-> !irq_o);

  p_default_vec_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && !irq_o) |=> (vec_o == DEF_VEC));

  p_vec_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take |=> $stable(vec_o));

  p_take_one_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_ext_o |-> (ext_req_i && irq_o));
endmodule

// File: rtl/irq_vec_unit.sv
module irq_vec_unit
  import irq_vec_pkg::*;
#(
  parameter int               EXT_PRIO = 4,
  parameter int               RX_PRIO  = 3,
  parameter int               VEC_W    = 16,
  parameter int               ADDR_W   = 24,
  parameter logic [ADDR_W-9:0] ADDR_HI = '1,
  parameter logic [VEC_W-1:0] EXT_VEC  = 16'h0028,
  parameter logic [VEC_W-1:0] RX_VEC   = 16'h0040,
  parameter logic [VEC_W-1:0] DEF_VEC  = 16'h0008,
  parameter logic [7:0]       CLR_CODE = 8'h0A
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pin_i,
  input  logic              rx_evt_i,
  input  logic              rx_rd_i,
  input  logic              mode_wr_i,
  input  logic              mode_level_i,
  input  logic              clr_wr_i,
  input  logic [7:0]        clr_code_i,
  input  logic              mask_wr_i,
  input  logic [2:0]        mask_i,
  input  logic              ack_i,
  input  logic              vec_rd_i,
  output logic              irq_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic [ADDR_W-1:0] vec_addr_o
);
  logic ext_req, rx_req, take_ext, ext_level;

  irq_pin_src #(.CLR_CODE(CLR_CODE)) u_pin (
    .clk_i, .rst_ni, .pin_i, .mode_wr_i, .mode_level_i, .clr_wr_i, .clr_code_i,
    .take_i (take_ext),
    .req_o  (ext_req),
    .level_o(ext_level)
  );

  irq_rx_src u_rx (
    .clk_i, .rst_ni,
    .set_i(rx_evt_i),
    .rd_i (rx_rd_i),
    .req_o(rx_req)
  );

  irq_arbiter #(
    .EXT_PRIO(EXT_PRIO), .RX_PRIO(RX_PRIO), .VEC_W(VEC_W),
    .EXT_VEC(EXT_VEC), .RX_VEC(RX_VEC), .DEF_VEC(DEF_VEC)
  ) u_arb (
    .clk_i, .rst_ni,
    .ext_req_i (ext_req),
    .rx_req_i  (rx_req),
    .mask_wr_i, .mask_i, .ack_i, .vec_rd_i,
    .irq_o, .vec_o,
    .take_ext_o(take_ext)
  );

  assign vec_addr_o = {ADDR_HI, vec_o[7:0]};

  p_level_no_clr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_ext && ext_level && pin_i) |=> ext_req || !pin_i || mode_wr_i);
endmodule

// File: tb/irq_vec_unit_bench.sv
module irq_vec_unit_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        pin_i = 1'b0, rx_evt_i = 1'b0, rx_rd_i = 1'b0;
  logic        mode_wr_i = 1'b0, mode_level_i = 1'b0;
  logic        clr_wr_i = 1'b0;
  logic [7:0]  clr_code_i = 8'h00;
  logic        mask_wr_i = 1'b0;
  logic [2:0]  mask_i = 3'd0;
  logic        ack_i = 1'b0, vec_rd_i = 1'b0;
  logic        irq_o, irq_t;
  logic [15:0] vec_o, vec_t;
  logic [23:0] vec_addr_o, addr_t;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  irq_vec_unit u_irq_vec_unit (
    .clk_i, .rst_ni, .pin_i, .rx_evt_i, .rx_rd_i, .mode_wr_i, .mode_level_i,
    .clr_wr_i, .clr_code_i, .mask_wr_i, .mask_i, .ack_i, .vec_rd_i,
    .irq_o, .vec_o, .vec_addr_o
  );

  // equal priorities: tie rule
  irq_vec_unit #(.EXT_PRIO(3), .RX_PRIO(3)) u_tie (
    .clk_i, .rst_ni, .pin_i, .rx_evt_i, .rx_rd_i, .mode_wr_i, .mode_level_i,
    .clr_wr_i, .clr_code_i, .mask_wr_i, .mask_i, .ack_i, .vec_rd_i,
    .irq_o(irq_t), .vec_o(vec_t), .vec_addr_o(addr_t)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk_i);
  endtask

  task automatic wr_mode(input logic lvl);
    mode_wr_i = 1'b1; mode_level_i = lvl; cyc(); mode_wr_i = 1'b0;
  endtask

  task automatic wr_clr(input logic [7:0] code);
    clr_wr_i = 1'b1; clr_code_i = code; cyc(); clr_wr_i = 1'b0;
  endtask

  task automatic wr_mask(input logic [2:0] m);
    mask_wr_i = 1'b1; mask_i = m; cyc(); mask_wr_i = 1'b0;
  endtask

  task automatic pin_pulse();
    pin_i = 1'b1; cyc(); pin_i = 1'b0; cyc();
  endtask

  task automatic rx_set();
    rx_evt_i = 1'b1; cyc(); rx_evt_i = 1'b0;
  endtask

  task automatic rx_read();
    rx_rd_i = 1'b1; cyc(); rx_rd_i = 1'b0;
  endtask

  task automatic ack_pulse();
    ack_i = 1'b1; cyc(); ack_i = 1'b0;
  endtask

  task automatic vrd_pulse();
    vec_rd_i = 1'b1; cyc(); vec_rd_i = 1'b0;
  endtask

  task automatic fetch();
    ack_pulse(); vrd_pulse();
  endtask

  function automatic logic [15:0] exp_vec(input int pe, input int pr, input int m,
                                         input bit e, input bit r);
    bit eo = e && (pe > m);
    bit ro = r && (pr > m);
    if (eo && (!ro || pe >= pr)) return 16'h0028;
    if (ro) return 16'h0040;
    return 16'h0008;
  endfunction

  initial begin
    repeat (3) cyc();
    rst_ni = 1'b1;
    cyc();
    // R1 reset state
    chk("R1 irq", 32'(irq_o), 32'd0);
    chk("R1 vec", 32'(vec_o), 32'h0);
    chk("R1 addr", 32'(vec_addr_o), 32'hFFFF00);
    pin_pulse();
    rx_set();
    cyc();
    chk("R1 mask 7 blocks", 32'(irq_o), 32'd0);
    wr_clr(8'h0A);
    rx_read();

    // R2 R7 R8 R9 R10 sweep: mask x pending sources, two priority sets
    for (int m = 0; m < 8; m++) begin
      for (int k = 0; k < 4; k++) begin
        bit e = k[0];
        bit r = k[1];
        logic [15:0] ev = exp_vec(4, 3, m, e, r);
        logic [15:0] tv = exp_vec(3, 3, m, e, r);
        wr_mask(3'(m));
        if (e) pin_pulse();
        if (r) rx_set();
        chk("R7 irq", 32'(irq_o), 32'((e && 4 > m) || (r && 3 > m)));
        chk("R7 tie irq", 32'(irq_t), 32'((e && 3 > m) || (r && 3 > m)));
        fetch();
        chk("R8 vec", 32'(vec_o), 32'(ev));
        chk("R8 tie vec", 32'(vec_t), 32'(tv));
        chk("R8 addr", 32'(vec_addr_o), {8'h00, 16'hFFFF, ev[7:0]});
        wr_mask(3'd0);
        chk("R10 after fetch", 32'(irq_o), 32'((e && ev != 16'h0028) || r));
        chk("R10 tie after fetch", 32'(irq_t), 32'((e && tv != 16'h0028) || r));
        wr_clr(8'h0A);
        rx_read();
      end
    end

    // R3 level follows pin without a clock edge
    wr_mode(1'b1);
    pin_i = 1'b1; #1;
    chk("R3 level rise", 32'(irq_o), 32'd1);
    cyc();
    pin_i = 1'b0; #1;
    chk("R3 level fall", 32'(irq_o), 32'd0);
    cyc();
    // R10 level fetch does not clear
    pin_i = 1'b1;
    fetch();
    chk("R10 level vec", 32'(vec_o), 32'h0028);
    chk("R10 level kept", 32'(irq_o), 32'd1);
    pin_i = 1'b0;
    cyc();
    wr_mode(1'b0);
    wr_clr(8'h0A);
    chk("R5 cleared base", 32'(irq_o), 32'd0);

    // R4 edge->level clears the flag
    pin_pulse();
    chk("R2 edge held", 32'(irq_o), 32'd1);
    wr_mode(1'b1);
    wr_mode(1'b0);
    chk("R4 flag cleared", 32'(irq_o), 32'd0);

    // R5 level->edge keeps the flag
    wr_mode(1'b1);
    pin_i = 1'b1; cyc();
    pin_i = 1'b0; cyc();
    chk("R3 withdrawn", 32'(irq_o), 32'd0);
    wr_mode(1'b0);
    chk("R5 flag kept", 32'(irq_o), 32'd1);
    wr_clr(8'h0B);
    chk("R5 other code", 32'(irq_o), 32'd1);
    wr_clr(8'h0A);
    chk("R5 code 0x0A", 32'(irq_o), 32'd0);

    // R6 receive flag ignores clear writes
    rx_set();
    wr_clr(8'h0A);
    chk("R6 clr 0x0A ignored", 32'(irq_o), 32'd1);
    wr_clr(8'h5A);
    chk("R6 clr other ignored", 32'(irq_o), 32'd1);
    rx_read();
    chk("R6 read clears", 32'(irq_o), 32'd0);

    // R9 default vector and vector read without ack
    fetch();
    chk("R9 default vec", 32'(vec_o), 32'h0008);
    chk("R9 default addr", 32'(vec_addr_o), 32'hFFFF08);
    rx_set();
    vrd_pulse();
    chk("R9 no ack hold", 32'(vec_o), 32'h0008);
    fetch();
    chk("R8 rx vec", 32'(vec_o), 32'h0040);
    chk("R10 rx kept", 32'(irq_o), 32'd1);
    rx_read();
    // R9 request vanishes between ack and vector read
    pin_pulse();
    ack_pulse();
    wr_clr(8'h0A);
    vrd_pulse();
    chk("R9 vanished", 32'(vec_o), 32'h0008);
    // R9 request appearing after ack is seen at vector read
    ack_pulse();
    pin_pulse();
    vrd_pulse();
    chk("R9 late request", 32'(vec_o), 32'h0028);
    chk("R10 edge consumed", 32'(irq_o), 32'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule